// File: doc/BRIEF.md
# Auto-Detecting Serial Control Port

A slave serial port that lets a host read and write a bank of internal registers over four wires: an active-low select, a serial clock and two data pins. Each time the select goes active the port looks at the level of the serial clock. A high clock selects a single-wire bidirectional convention of the kind used by microcontroller shift-register mode 0. A low clock selects a two-wire SPI mode 0 / Microwire-style convention. The chosen convention holds until the select is released. It fixes which pin carries host data, which pin returns data and the bit order.

Every transaction is a command byte followed by one data byte. The command byte carries a read flag and a register address. The port shows the address to the register bank and pulses a write strobe after a write. For a read it fetches the addressed value and shifts it back to the host. All serial pins are brought into the system clock domain through two-flop synchronisers. The port finds the serial clock edges by oversampling, so the serial clock must be several times slower than the system clock.

Top module: `scp_top`

## Requirements
- R1: On each activation of the select (cs_ni going low), the serial clock level is latched as the transaction mode: high selects single-wire mode, low selects two-wire mode. The mode holds until cs_ni returns high.
- R2: In single-wire mode, host bits are taken from data1_i on serial clock rising edges, least significant bit first, and data2_i has no effect.
- R3: In two-wire mode (clock polarity 0, phase 0), host bits are taken from data2_i on rising edges, most significant bit first, and data1_i has no effect.
- R4: The command byte, once assembled in its mode's bit order, holds the read flag in bit 7 (1 = read, 0 = write) and the register address in bits 6:0.
- R5: A write raises reg_we_o for exactly one clock after the 16th rising edge, with reg_addr_o equal to the command address and reg_wdata_o equal to the data byte.
- R6: A read returns reg_rdata_i for the command address on data1_o. The first data bit is presented after the falling edge that follows the 8th rising edge, and each later falling edge presents the next bit in the mode's bit order.
- R7: In single-wire mode, data1_oe_o is high only during the data byte of a read. In two-wire mode, data1_oe_o is high for the whole active select. With the select inactive it is low.
- R8: Releasing the select before the 16th rising edge aborts the transaction. No write strobe is raised, the bit count returns to zero and the next transaction decodes from its first bit.
- R9: After reset, reg_we_o, data1_oe_o and data1_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Active-low select from host |
| sclk_i | input | 1 | Serial clock from host |
| data1_i | input | 1 | Input side of the shared data pin |
| data1_o | output | 1 | Output side of the shared data pin |
| data1_oe_o | output | 1 | Drive enable of the shared data pin |
| data2_i | input | 1 | Receive data pin (two-wire mode) |
| reg_addr_o | output | ADDR_W | Register address from command |
| reg_wdata_o | output | DATA_W | Register write data |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_rdata_i | input | DATA_W | Read data for reg_addr_o |

## Verification
The bench uses the default ADDR_W of 7 and DATA_W of 8, so all 128 addresses and the read-flag bit position can be reached by random commands. It sets the serial clock half-period to 8 system clocks, which leaves room for the synchroniser delay before each host sample. Random transactions mix both modes, reads and writes, and drive the unused data pin with random values. Directed cases abort the select inside the command byte and inside the data byte.

// File: rtl/scp_pkg.sv
package scp_pkg;
  typedef enum logic {
    MODE_2W = 1'b0,
    MODE_1W = 1'b1
  } scp_mode_e;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s > 0) ? s-1 : 0];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/scp_rx_shift.sv
module scp_rx_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         lsb_first_i,
  input  logic         bit_i,
  output logic [W-1:0] data_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sh_q <= '0;
    else if (clr_i)    sh_q <= '0;
    else if (shift_i)  sh_q <= lsb_first_i ? {bit_i, sh_q[W-1:1]} : {sh_q[W-2:0], bit_i};
  end

  assign data_o = sh_q;
endmodule

// File: rtl/scp_top.sv
module scp_top
  import scp_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              data1_i,
  output logic              data1_o,
  output logic              data1_oe_o,
  input  logic              data2_i,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  localparam int unsigned CMD_W = ADDR_W + 1;
  localparam int unsigned TOT   = CMD_W + DATA_W;
  localparam int unsigned CNT_W = $clog2(TOT + 1);
  localparam logic [CNT_W-1:0] CNT_CMD = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0] CNT_TOT = CNT_W'(TOT);

  logic [3:0] pins_s;
  logic       cs_s, sclk_s, d1_s, d2_s;

  scp_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0001)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({data2_i, data1_i, sclk_i, cs_ni}),
    .q_o   (pins_s)
  );
  assign {d2_s, d1_s, sclk_s, cs_s} = pins_s;

  logic      cs_act_q, sclk_prev_q;
  scp_mode_e mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic      start, rise, fall, in_cmd, in_data, rx_bit, lsb_first;

  assign start   = !cs_s && !cs_act_q;
  assign rise    = cs_act_q && !cs_s && sclk_s && !sclk_prev_q;
  assign fall    = cs_act_q && !cs_s && !sclk_s && sclk_prev_q;
  assign in_cmd  = cnt_q < CNT_CMD;
  assign in_data = !in_cmd && (cnt_q < CNT_TOT);
  assign lsb_first = (mode_q == MODE_1W);
  assign rx_bit  = lsb_first ? d1_s : d2_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_act_q    <= 1'b0;
      sclk_prev_q <= 1'b0;
      mode_q      <= MODE_2W;
      cnt_q       <= '0;
    end else begin
      cs_act_q    <= !cs_s;
      sclk_prev_q <= sclk_s;
      if (start) mode_q <= sclk_s ? MODE_1W : MODE_2W;
      if (cs_s)                     cnt_q <= '0;
      else if (rise && cnt_q < CNT_TOT) cnt_q <= cnt_q + 1'b1;
    end
  end

  logic [CMD_W-1:0]  cmd_w;
  logic [DATA_W-1:0] wdat_w;

  scp_rx_shift #(.W(CMD_W)) u_cmd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (start),
    .shift_i    (rise && in_cmd),
    .lsb_first_i(lsb_first),
    .bit_i      (rx_bit),
    .data_o     (cmd_w)
  );

  scp_rx_shift #(.W(DATA_W)) u_wdat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (start),
    .shift_i    (rise && in_data),
    .lsb_first_i(lsb_first),
    .bit_i      (rx_bit),
    .data_o     (wdat_w)
  );

  logic rd;
  assign rd          = cmd_w[CMD_W-1];
  assign reg_addr_o  = cmd_w[ADDR_W-1:0];
  assign reg_wdata_o = wdat_w;

  // command completes on the rise that brings cnt to CMD_W; fetch one cycle later
  logic cmd_done_q, we_q, dout_q;
  logic [DATA_W-1:0] tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_done_q <= 1'b0;
      we_q       <= 1'b0;
      tx_q       <= '0;
      dout_q     <= 1'b0;
    end else begin
      cmd_done_q <= rise && (cnt_q == CNT_CMD - 1'b1);
      we_q       <= rise && (cnt_q == CNT_TOT - 1'b1) && !rd;
      if (cs_s) begin
        tx_q   <= '0;
        dout_q <= 1'b0;
      end else if (cmd_done_q) begin
        tx_q <= reg_rdata_i;
      end else if (fall && in_data && rd) begin
        dout_q <= lsb_first ? tx_q[0] : tx_q[DATA_W-1];
        tx_q   <= lsb_first ? {1'b0, tx_q[DATA_W-1:1]} : {tx_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign reg_we_o   = we_q;
  assign data1_o    = dout_q;
  assign data1_oe_o = cs_act_q && ((mode_q == MODE_2W) || (rd && in_data));
endmodule

// File: rtl/scp_checker.sv
module scp_checker #(
  parameter int unsigned CNT_W = 5,
  parameter int unsigned TOT   = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_act_q,
  input logic             mode_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             fall,
  input logic             reg_we_o,
  input logic             data1_o
);
  a_r1_mode_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_act_q && $past(cs_act_q)) |-> $stable(mode_q));

  a_r5_we_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  a_r5_we_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> (cnt_q == CNT_W'(TOT)));

  a_r8_cnt_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_q |-> (cnt_q == '0));

  a_r6_dout_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_act_q && $past(cs_act_q) && !$past(fall)) |-> $stable(data1_o));
endmodule

bind scp_top scp_checker #(.CNT_W(CNT_W), .TOT(TOT)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_act_q(cs_act_q),
  .mode_q  (mode_q),
  .cnt_q   (cnt_q),
  .fall    (fall),
  .reg_we_o(reg_we_o),
  .data1_o (data1_o)
);

// File: tb/tb_scp_top.sv
module tb_scp_top;
  localparam int H = 8;

  logic clk = 0, rst_n = 0;
  logic cs_n = 1, sclk = 0, d1 = 0, d2 = 0;
  logic data1_o, data1_oe, we;
  logic [6:0] addr;
  logic [7:0] wdata, rdata;
  logic [7:0] bank [128];
  logic [7:0] expm [128];

  int checks = 0, errors = 0, we_cnt = 0;
  logic [6:0] mon_addr;
  logic [7:0] mon_data;
  bit done = 0;

  always #5 clk = ~clk;

  scp_top dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk),
    .data1_i(d1), .data1_o(data1_o), .data1_oe_o(data1_oe), .data2_i(d2),
    .reg_addr_o(addr), .reg_wdata_o(wdata), .reg_we_o(we), .reg_rdata_i(rdata)
  );

  assign rdata = bank[addr];

  always @(posedge clk) if (we) begin
    bank[addr] <= wdata;
    we_cnt   <= we_cnt + 1;
    mon_addr <= addr;
    mon_data <= wdata;
  end

  function automatic logic bitof(input logic [7:0] b, input int j, input bit uc);
    return uc ? b[j] : b[7-j];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // one transaction of nbits rising edges; uc=1 single-wire mode
  task automatic xfer(input bit uc, input bit rd, input logic [6:0] a,
                      input logic [7:0] wd, input int nbits,
                      output logic [7:0] rv, output bit oe_ok);
    logic [7:0] cmd;
    cmd = {rd, a};
    rv = '0;
    oe_ok = 1;
    sclk = uc;
    wclk(6);
    cs_n = 0;
    wclk(6);
    for (int i = 0; i < nbits; i++) begin
      logic b;
      b = (i < 8) ? bitof(cmd, i, uc) : bitof(wd, i - 8, uc);
      sclk = 0;
      if (uc) begin d1 = b; d2 = $urandom; end
      else    begin d2 = b; d1 = $urandom; end
      wclk(H);
      if (uc) begin
        if (data1_oe !== ((i >= 8) && rd)) oe_ok = 0;
      end else if (data1_oe !== 1'b1) oe_ok = 0;
      if (i >= 8 && rd) begin
        if (uc) rv[i-8] = data1_o; else rv[15-i] = data1_o;
      end
      sclk = 1;
      wclk(H);
    end
    if (!uc) sclk = 0;
    wclk(4);
    cs_n = 1;
    wclk(8);
    if (data1_oe !== 1'b0) oe_ok = 0;
  endtask

  task automatic full(input bit uc, input bit rd, input logic [6:0] a, input logic [7:0] wd);
    logic [7:0] rv;
    bit ok;
    int wc0;
    string mr;
    mr = uc ? "R2" : "R3";
    wc0 = we_cnt;
    xfer(uc, rd, a, wd, 16, rv, ok);
    chk(ok, "R7 oe pattern", uc, rd);
    if (rd) begin
      chk(rv === expm[a], {"R6 ", mr, " read data"}, rv, expm[a]);
      chk(we_cnt == wc0, "R4 read makes no write", we_cnt, wc0);
    end else begin
      chk(we_cnt == wc0 + 1, "R5 one write strobe", we_cnt, wc0 + 1);
      chk(mon_addr === a, {"R4 ", mr, " write address"}, mon_addr, a);
      chk(mon_data === wd, {"R5 ", mr, " write data"}, mon_data, wd);
      expm[a] = wd;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    bit ok;
    int wc0;
    void'($urandom(32'h5C0DE));
    for (int i = 0; i < 128; i++) begin
      bank[i] = 8'(i * 37 + 5);
      expm[i] = 8'(i * 37 + 5);
    end
    wclk(3);
    // R9 reset state
    chk(we === 1'b0 && data1_oe === 1'b0 && data1_o === 1'b0, "R9 reset outputs",
        {we, data1_oe, data1_o}, 0);
    rst_n = 1;
    wclk(4);

    // R1 directed: mode per transaction via sclk level
    full(1, 0, 7'h55, 8'hA3);
    full(0, 1, 7'h55, 8'h00);
    full(0, 0, 7'h7F, 8'h3C);
    full(1, 1, 7'h7F, 8'h00);
    full(1, 1, 7'h00, 8'h00);
    full(0, 1, 7'h01, 8'h00);

    // R8 abort inside data byte of write
    wc0 = we_cnt;
    xfer(1, 0, 7'h10, 8'hFF, 12, rv, ok);
    chk(we_cnt == wc0, "R8 abort in data no write", we_cnt, wc0);
    full(0, 1, 7'h10, 8'h00);
    // R8 abort inside command, next decodes from bit 0
    wc0 = we_cnt;
    xfer(0, 0, 7'h22, 8'h11, 3, rv, ok);
    chk(we_cnt == wc0, "R8 abort in command no write", we_cnt, wc0);
    full(0, 0, 7'h22, 8'h99);
    full(1, 1, 7'h22, 8'h00);

    // random mix
    for (int n = 0; n < 120; n++) begin
      bit uc, rd;
      logic [6:0] a;
      logic [7:0] wd;
      uc = $urandom; rd = $urandom;
      a = $urandom; wd = $urandom;
      if (n % 3 == 0) a = 7'h22 + 7'(n % 4);
      full(uc, rd, a, wd);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule